// File: doc/BRIEF.md
# Timer Compare Channel with Pulse Output

This block is one compare channel that watches a free-running time counter. Software gives it a target counter value and an operating mode. When the counter reaches the target, the channel raises a sticky event flag, can raise an interrupt, and drives an output pin. In the toggle mode the pin flips on each event. In the pulse mode the pin goes high for a fixed number of cycles. Several instances can share one counter.

The target register is double-buffered, which suits periodic outputs such as a one-pulse-per-second signal. While the channel is disabled, a write to the target loads the active slot directly. Once the channel is enabled, a write goes into a queue slot, and that slot is promoted when the next event fires. Software therefore always works one event ahead. It services each event by clearing the flag and writing the target that follows the one just promoted. A control input chooses what a counter wrap does. Either matching carries on across the wrap, or the channel disarms until a new target is written.

Top module: `cmp_channel`

## Requirements
- R1: After reset, status_o, cmp_active_o, pin_o and irq_o are all zero, and no match is possible until a target has been written.
- R2: A control write (wr_sel_i=0) stores wr_data_i[5:2] as the mode and wr_data_i[6] as the interrupt enable. status_o reads {flag, enable, mode, 2'b00}, so bits 1:0 always read 0. Writing 1 to bit 7 clears the flag and writing 0 to it leaves the flag alone. A match in the same cycle as a clear wins.
- R3: A target write (wr_sel_i=1) keeps only the low CNT_W bits of wr_data_i. If the mode is 0, it loads the active target at once. If the mode is non-zero, it fills the queue slot and leaves the active target unchanged.
- R4: A match occurs when all of these hold: the mode is non-zero, the channel is armed, and cnt_i equals the active target. The flag is set on the clock edge that samples the match.
- R5: On a match, a queued target becomes the active target and the queue empties. With an empty queue, the active target stays the same.
- R6: In mode 4'h5 the pin inverts on every match.
- R7: In mode 4'hF a match drives the pin high for exactly PULSE_LEN cycles, starting with the edge that samples the match. A new match during the pulse restarts it.
- R8: irq_o is high exactly when both the flag and the interrupt enable are set.
- R9: A cycle in which cnt_i is below its previous value counts as a wrap. With wrap_keep_i=0, a wrap disarms the channel (including the wrapping sample) until the next target write. With wrap_keep_i=1, matching continues.
- R10: A control write with mode 0 forces the pin low and discards any queued target.
- R11: Any other non-zero mode sets the flag on a match and leaves the pin unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | CNT_W | Free-running time counter value |
| wrap_keep_i | input | 1 | 1 keeps matching across a counter wrap |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 selects control/status, 1 selects target |
| wr_data_i | input | 32 | Write data |
| status_o | output | 8 | {flag, irq enable, mode[3:0], 2'b00} |
| cmp_active_o | output | CNT_W | Target currently being compared |
| pin_o | output | 1 | Compare output pin |
| irq_o | output | 1 | Interrupt request |

## Verification
A fault in the queue slot shows up on cmp_active_o on the cycle after the next match, when the wrong value is promoted or a stale value is kept. A bad flag or arm state shows up in status_o and irq_o one cycle after the counter passes the target. A fault in the pulse counter changes the width of the high level on pin_o within PULSE_LEN+1 cycles of the match. The random phase checks every output on every cycle, so any such divergence is caught within one event of its cause.

// File: rtl/cmp_channel.sv
`timescale 1ns/1ps
module cmp_channel #(
  parameter int CNT_W       = 31,
  parameter int PULSE_LEN   = 1,
  parameter logic [3:0] MODE_TOGGLE = 4'h5,
  parameter logic [3:0] MODE_PULSE  = 4'hF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wrap_keep_i,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [31:0]      wr_data_i,
  output logic [7:0]       status_o,
  output logic [CNT_W-1:0] cmp_active_o,
  output logic             pin_o,
  output logic             irq_o
);
  localparam int PW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;

  logic [3:0]       mode_q;
  logic             ie_q, flag_q, armed_q, pend_v_q, pin_q;
  logic [CNT_W-1:0] act_q, pend_q, prev_q;
  logic [PW-1:0]    left_q;

  wire             wr_ctl  = wr_en_i & ~wr_sel_i;
  wire             wr_cmp  = wr_en_i & wr_sel_i;
  wire [3:0]       wr_mode = wr_data_i[5:2];
  wire [CNT_W-1:0] wr_val  = wr_data_i[CNT_W-1:0];
  wire             wrapped = cnt_i < prev_q;
  wire             live    = armed_q & ~(wrapped & ~wrap_keep_i);
  wire             hit     = live & (mode_q != 4'd0) & (cnt_i == act_q);
  wire             go_off  = wr_ctl & (wr_mode == 4'd0);

  assign status_o     = {flag_q, ie_q, mode_q, 2'b00};
  assign cmp_active_o = act_q;
  assign pin_o        = pin_q;
  assign irq_o        = flag_q & ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      ie_q     <= 1'b0;
      flag_q   <= 1'b0;
      armed_q  <= 1'b0;
      pend_v_q <= 1'b0;
      pin_q    <= 1'b0;
      act_q    <= '0;
      pend_q   <= '0;
      prev_q   <= '0;
      left_q   <= '0;
    end else begin
      prev_q <= cnt_i;

      if (wr_ctl) begin
        mode_q <= wr_mode;
        ie_q   <= wr_data_i[6];
      end

      if (hit)                        flag_q <= 1'b1;
      else if (wr_ctl && wr_data_i[7]) flag_q <= 1'b0;

      if (wr_cmp)                          armed_q <= 1'b1;
      else if (wrapped && !wrap_keep_i)    armed_q <= 1'b0;

      if (wr_cmp && mode_q == 4'd0) act_q <= wr_val;
      else if (hit && pend_v_q)     act_q <= pend_q;

      if (wr_cmp && mode_q != 4'd0) begin
        pend_q   <= wr_val;
        pend_v_q <= 1'b1;
      end else if (wr_cmp || go_off || (hit && pend_v_q)) begin
        pend_v_q <= 1'b0;
      end

      if (go_off) begin
        pin_q  <= 1'b0;
        left_q <= '0;
      end else if (hit && mode_q == MODE_TOGGLE) begin
        pin_q <= ~pin_q;
      end else if (hit && mode_q == MODE_PULSE) begin
        pin_q  <= 1'b1;
        left_q <= PW'(PULSE_LEN - 1);
      end else if (mode_q == MODE_PULSE && pin_q) begin
        if (left_q == '0) pin_q  <= 1'b0;
        else              left_q <= left_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmp_channel_chk.sv
`timescale 1ns/1ps
module cmp_channel_chk #(
  parameter int CNT_W = 31
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_i,
  input logic             wr_en_i,
  input logic             wr_sel_i,
  input logic [31:0]      wr_data_i,
  input logic [7:0]       status_o,
  input logic [CNT_W-1:0] cmp_active_o,
  input logic             pin_o,
  input logic             irq_o
);
  a_r4_flag_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[7]) |-> ($past(cnt_i) == $past(cmp_active_o)) && ($past(status_o[5:2]) != 4'd0));

  a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[7] && !(wr_en_i && !wr_sel_i && wr_data_i[7]) |=> status_o[7]);

  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> status_o[7] && status_o[6]);

  a_r5_active_moves_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmp_active_o) |-> $past(wr_en_i && wr_sel_i) || ($past(cnt_i) == $past(cmp_active_o)));

  a_r3_queue_keeps_active: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && wr_sel_i && status_o[5:2] != 4'd0 && cnt_i != cmp_active_o |=> $stable(cmp_active_o));

  a_r6_pin_rises_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_o) |-> $past(cnt_i) == $past(cmp_active_o));
endmodule

bind cmp_channel cmp_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .wr_en_i(wr_en_i),
  .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .status_o(status_o),
  .cmp_active_o(cmp_active_o), .pin_o(pin_o), .irq_o(irq_o)
);

// File: tb/cmp_channel_bench.sv
`timescale 1ns/1ps
module cmp_channel_bench;
  localparam int CW = 31;
  localparam int PL = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0] cnt_i = '0;
  logic wrap_keep_i = 1'b1, wr_en_i = 1'b0, wr_sel_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [7:0] status_o;
  logic [CW-1:0] cmp_active_o;
  logic pin_o, irq_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  cmp_channel #(.CNT_W(CW), .PULSE_LEN(PL)) u_cmp_channel (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .wrap_keep_i(wrap_keep_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .status_o(status_o), .cmp_active_o(cmp_active_o), .pin_o(pin_o), .irq_o(irq_o)
  );

  always #2.5 clk = ~clk;

  // reference model state
  logic [3:0] m_mode; logic m_ie, m_flag, m_armed, m_pv, m_pin;
  logic [CW-1:0] m_act, m_pend, m_prev; int m_left;

  task automatic model_reset();
    m_mode = 0; m_ie = 0; m_flag = 0; m_armed = 0; m_pv = 0; m_pin = 0;
    m_act = 0; m_pend = 0; m_prev = 0; m_left = 0;
  endtask

  task automatic cyc();
    logic wrp, hit, wc, wm, off;
    logic [3:0] nm; logic [CW-1:0] v;
    wc = wr_en_i & ~wr_sel_i; wm = wr_en_i & wr_sel_i;
    nm = wr_data_i[5:2]; v = wr_data_i[CW-1:0];
    off = wc && nm == 4'd0;
    wrp = cnt_i < m_prev;
    hit = m_armed && !(wrp && !wrap_keep_i) && m_mode != 0 && cnt_i == m_act;
    @(negedge clk);
    m_prev = cnt_i;
    if (hit) m_flag = 1; else if (wc && wr_data_i[7]) m_flag = 0;
    if (wm) m_armed = 1; else if (wrp && !wrap_keep_i) m_armed = 0;
    if (off) begin m_pin = 0; m_left = 0; end
    else if (hit && m_mode == 4'h5) m_pin = ~m_pin;
    else if (hit && m_mode == 4'hF) begin m_pin = 1; m_left = PL - 1; end
    else if (m_mode == 4'hF && m_pin) begin
      if (m_left == 0) m_pin = 0; else m_left--;
    end
    if (wm && m_mode == 0) begin m_act = v; m_pv = 0; end
    else if (wm) begin
      if (hit && m_pv) m_act = m_pend;
      m_pend = v; m_pv = 1;
    end else if (hit && m_pv) begin m_act = m_pend; m_pv = 0; end
    else if (off) m_pv = 0;
    if (wc) begin m_mode = nm; m_ie = wr_data_i[6]; end
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [31:0] d);
    wr_en_i = 1; wr_sel_i = sel; wr_data_i = d;
    cyc();
    wr_en_i = 0;
  endtask

  task automatic hit_at(logic [CW-1:0] v);
    cnt_i = v; cyc(); cnt_i = 50;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    cnt_i = 50;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    chk("R1 status", status_o, 0); chk("R1 active", cmp_active_o, 0);
    chk("R1 pin", pin_o, 0); chk("R1 irq", irq_o, 0);
    cnt_i = 0; cyc(); cnt_i = 50; cyc();
    chk("R1 no match unarmed", status_o[7], 0);
    // R2 reserved bits
    wr(0, 32'h3); chk("R2 low bits zero", status_o, 8'h00);
    // R3 direct load, upper bits dropped
    wr(1, 32'hFFFF_FF10); chk("R3 direct load", cmp_active_o, 31'h7FFF_FF10);
    wr(0, 32'h54); chk("R2 mode/ie", status_o, 8'h54);
    wr(1, 200); chk("R3 queued keeps active", cmp_active_o, 31'h7FFF_FF10);
    hit_at(31'h7FFF_FF10);
    chk("R4 flag", status_o, 8'hD4); chk("R8 irq on", irq_o, 1);
    chk("R6 toggle up", pin_o, 1); chk("R5 promote", cmp_active_o, 200);
    wr(0, 32'h54); chk("R2 write0 keeps flag", status_o[7], 1);
    wr(0, 32'hD4); chk("R2 w1c", status_o, 8'h54); chk("R8 irq off", irq_o, 0);
    hit_at(200);
    chk("R6 toggle down", pin_o, 0); chk("R5 empty queue", cmp_active_o, 200);
    wr(0, 32'h94); chk("R2 ie off", status_o, 8'h14);
    hit_at(200); chk("R8 flag no irq", {status_o[7], irq_o}, 2'b10);
    // R7 pulse
    wr(0, 32'hBC); chk("R7 mode", status_o, 8'h3C);
    hit_at(200);
    chk("R7 pulse c1", pin_o, 1); cyc(); chk("R7 pulse c2", pin_o, 1);
    cyc(); chk("R7 pulse c3", pin_o, 1); cyc(); chk("R7 pulse end", pin_o, 0);
    // R11
    wr(0, 32'h94); hit_at(200); chk("R6 pin up", pin_o, 1);
    wr(0, 32'h8C); hit_at(200);
    chk("R11 flag", status_o[7], 1); chk("R11 pin held", pin_o, 1);
    // R10
    wr(1, 300); wr(0, 32'h80);
    chk("R10 pin low", pin_o, 0); chk("R10 active", cmp_active_o, 200);
    wr(0, 32'h14); hit_at(200);
    chk("R10 flag", status_o[7], 1); chk("R10 queue dropped", cmp_active_o, 200);
    // R9
    wrap_keep_i = 0;
    wr(0, 32'h94);
    cnt_i = 1000; cyc(); cnt_i = 10; cyc();
    hit_at(200); chk("R9 disarmed", status_o[7], 0);
    wr(1, 200); hit_at(200); chk("R9 rearmed", status_o[7], 1);
    wr(0, 32'h94); wrap_keep_i = 1; wr(1, 200);
    cnt_i = 1000; cyc(); cnt_i = 10; cyc();
    hit_at(200); chk("R9 keep across wrap", status_o[7], 1);
    // random phase against model
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom % 100;
      wrap_keep_i = ($urandom % 8) != 0;
      wr_en_i = r < 20;
      wr_sel_i = $urandom % 2;
      if (!wr_sel_i) begin
        logic [3:0] md;
        case ($urandom % 4) 0: md = 0; 1: md = 5; 2: md = 4'hF; default: md = 3; endcase
        wr_data_i = {24'($urandom), 1'($urandom), 1'($urandom), md, 2'($urandom)};
      end else begin
        wr_data_i = {$urandom} & 32'hFFFF_003F;
        if ($urandom % 2) wr_data_i[30:6] = '0;
      end
      cnt_i = ($urandom % 3 == 0) ? m_act : CW'($urandom % 64);
      cyc();
      chk("R4 R2 random status", status_o, {m_flag, m_ie, m_mode, 2'b00});
      chk("R5 R3 random active", cmp_active_o, m_act);
      chk("R6 R7 random pin", pin_o, m_pin);
      chk("R8 random irq", irq_o, m_flag & m_ie);
    end
    wr_en_i = 0;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule